// File: doc/BRIEF.md
# Disk Command Block Register Bank with Two-Deep Byte Stacks

This block is the host-facing register file that sits between a parallel register bus and the command decoder of a disk device controller. The host programs the addressing and transfer parameters of the next command by writing bytes. It then writes the command code. The five parameter registers (features, sector count and the three LBA bytes) each keep two bytes: the newest one written and the one it displaced. A host can therefore load a 48-bit address by writing each register twice, high byte first.

A high-order-select bit in the device control register picks which of the two bytes a read returns. Any write to a command-block register clears that bit. From the stored bytes the block continuously presents the values the decoder needs:
- a 48-bit LBA and a 28-bit LBA;
- a 16-bit feature value;
- the sector count in both its 8-bit and 16-bit forms, expanded to a true count of sectors.

Both forms are always available, so 28-bit and 48-bit commands may be mixed freely. A one-cycle strobe carries each command code to the decoder.

Register map (4-bit address): 1 features, 2 sector count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 command, 8 device control. Addresses 0 and 9 to 15 hold no register.

Top module: `tf_regbank`

## Requirements
- R1: A bus write (cs=1, wr=1) to address 1, 2, 3, 4 or 5 moves that register's newest byte into its previous slot and stores the written byte as the newest one; the change is visible from the next clock cycle.
- R2: A read (cs=1, rd=1) of address 1 to 5 returns the previous byte of that register when `hob`=1 and the newest byte when `hob`=0; `bus_rdata` is combinational on the address.
- R3: A write to any address from 1 to 7 clears `hob` to 0 on the next cycle.
- R4: A write to address 1 to 5 updates the newest byte whether `hob` is 0 or 1 at the time.
- R5: A write to address 8 stores the whole device control byte, sets `hob` to its bit 7, and leaves all five stacks untouched; reading address 8 returns the stored byte.
- R6: `lba48` is {prev LBA high, prev LBA mid, prev LBA low, newest LBA high, newest LBA mid, newest LBA low}, most significant byte first.
- R7: `lba28` is {device bits 3:0, newest LBA high, newest LBA mid, newest LBA low}; a write to address 6 stores the device byte, and a read of address 6 returns it.
- R8: `scnt28` equals the newest sector count byte, except that 0 gives 256.
- R9: `scnt48` equals {previous, newest} sector count, except that 0 gives 65536.
- R10: `feat16` is {previous features byte, newest features byte}.
- R11: A write to address 7 raises `cmd_stb` for exactly the next cycle, with `cmd_code` equal to the written byte; otherwise `cmd_stb` is 0.
- R12: Reset clears all stacks, the device byte, the device control byte (so `hob`=0) and `cmd_stb`.
- R13: Writes with cs=0 and writes to addresses 0 or 9 to 15 change nothing, `hob` included. Reads of those addresses, or of address 7, return 0, and `bus_rdata` is 0 whenever no read is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Register bus chip select |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| hob | output | 1 | High-order-select bit (device control bit 7) |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_code | output | 8 | Command code of the last command write |
| lba48 | output | 48 | Assembled 48-bit LBA |
| lba28 | output | 28 | Assembled 28-bit LBA |
| scnt28 | output | 9 | Sector count of a 28-bit command (1 to 256) |
| scnt48 | output | 17 | Sector count of a 48-bit command (1 to 65536) |
| feat16 | output | 16 | 16-bit feature value |

## Verification
The hardest case to reach is a register write that arrives while `hob` is set. That single write must store a new byte, shift the old newest byte into the previous slot and clear `hob`. Any fault shows only on a later read made after `hob` has been set again.

The stimulus table sets the bit through address 8 and then writes a stacked register. It reads address 8 to confirm the clear, sets the bit again and reads both bytes back. It also writes device control between pushes, to prove the stacks stay put.

// File: rtl/tf_regbank_pkg.sv
package tf_regbank_pkg;
    localparam int TF_BYTE_W   = 8;
    localparam int TF_N_STACK  = 5;
    localparam int TF_DEVNIB_W = 4;
    localparam int TF_LBA48_W  = 6 * TF_BYTE_W;
    localparam int TF_LBA28_W  = 3 * TF_BYTE_W + TF_DEVNIB_W;
    localparam int TF_CNT28_W  = TF_BYTE_W + 1;
    localparam int TF_CNT48_W  = 2 * TF_BYTE_W + 1;

    // stack index order; the bus address of stack i is i+1
    localparam int STK_FEAT = 0;
    localparam int STK_SCNT = 1;
    localparam int STK_LBAL = 2;
    localparam int STK_LBAM = 3;
    localparam int STK_LBAH = 4;

    localparam int ADR_DEV  = 6;
    localparam int ADR_CMD  = 7;
    localparam int ADR_DCTL = 8;

    typedef logic [TF_BYTE_W-1:0] tf_byte_t;

    typedef struct packed {
        tf_byte_t dev;
        tf_byte_t dctl;
        logic     cmd_stb;
        tf_byte_t cmd_code;
    } tf_ctrl_t;
endpackage

// File: rtl/tf_addr_decode.sv
module tf_addr_decode
    import tf_regbank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                  bus_cs,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    output logic [TF_N_STACK-1:0] push,
    output logic                  dev_we,
    output logic                  cmd_we,
    output logic                  dctl_we,
    output logic                  blk_we
);
    logic wr_en;
    assign wr_en = bus_cs && bus_wr;

    for (genvar i = 0; i < TF_N_STACK; i++) begin : g_push
        assign push[i] = wr_en && (bus_addr == ADDR_W'(i + 1));
    end

    assign dev_we  = wr_en && (bus_addr == ADDR_W'(ADR_DEV));
    assign cmd_we  = wr_en && (bus_addr == ADDR_W'(ADR_CMD));
    assign dctl_we = wr_en && (bus_addr == ADDR_W'(ADR_DCTL));
    assign blk_we  = (|push) || dev_we || cmd_we;
endmodule

// File: rtl/tf_byte_stack.sv
module tf_byte_stack #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] newest,
    output logic [W-1:0] older
);
    typedef struct packed {
        logic [W-1:0] newest;
        logic [W-1:0] older;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push) begin
            stk_d.older  = stk_q.newest;
            stk_d.newest = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    assign newest = stk_q.newest;
    assign older  = stk_q.older;
endmodule

// File: rtl/tf_param_assemble.sv
module tf_param_assemble
    import tf_regbank_pkg::*;
(
    input  tf_byte_t [TF_N_STACK-1:0] newest,
    input  tf_byte_t [TF_N_STACK-1:0] older,
    input  tf_byte_t                  dev,
    output logic [TF_LBA48_W-1:0]     lba48,
    output logic [TF_LBA28_W-1:0]     lba28,
    output logic [TF_CNT28_W-1:0]     scnt28,
    output logic [TF_CNT48_W-1:0]     scnt48,
    output logic [2*TF_BYTE_W-1:0]    feat16
);
    logic [2*TF_BYTE_W-1:0] cnt_pair;

    assign lba48 = {older[STK_LBAH], older[STK_LBAM], older[STK_LBAL],
                    newest[STK_LBAH], newest[STK_LBAM], newest[STK_LBAL]};
    assign lba28 = {dev[TF_DEVNIB_W-1:0],
                    newest[STK_LBAH], newest[STK_LBAM], newest[STK_LBAL]};
    assign feat16   = {older[STK_FEAT], newest[STK_FEAT]};
    assign cnt_pair = {older[STK_SCNT], newest[STK_SCNT]};

    always_comb begin
        if (newest[STK_SCNT] == '0) scnt28 = {1'b1, {TF_BYTE_W{1'b0}}};
        else                        scnt28 = {1'b0, newest[STK_SCNT]};
        if (cnt_pair == '0)         scnt48 = {1'b1, {(2*TF_BYTE_W){1'b0}}};
        else                        scnt48 = {1'b0, cnt_pair};
    end
endmodule

// File: rtl/tf_regbank.sv
module tf_regbank
    import tf_regbank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_cs,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic                   bus_rd,
    input  logic [TF_BYTE_W-1:0]   bus_wdata,
    output logic [TF_BYTE_W-1:0]   bus_rdata,
    output logic                   hob,
    output logic                   cmd_stb,
    output logic [TF_BYTE_W-1:0]   cmd_code,
    output logic [TF_LBA48_W-1:0]  lba48,
    output logic [TF_LBA28_W-1:0]  lba28,
    output logic [TF_CNT28_W-1:0]  scnt28,
    output logic [TF_CNT48_W-1:0]  scnt48,
    output logic [2*TF_BYTE_W-1:0] feat16
);
    logic [TF_N_STACK-1:0]     push;
    logic                      dev_we, cmd_we, dctl_we, blk_we;
    tf_byte_t [TF_N_STACK-1:0] newest, older;
    tf_ctrl_t                  ctl_d, ctl_q;

    tf_addr_decode #(.ADDR_W(ADDR_W)) i_dec (
        .bus_cs  (bus_cs),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .push    (push),
        .dev_we  (dev_we),
        .cmd_we  (cmd_we),
        .dctl_we (dctl_we),
        .blk_we  (blk_we)
    );

    for (genvar i = 0; i < TF_N_STACK; i++) begin : g_stk
        tf_byte_stack #(.W(TF_BYTE_W)) i_stk (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[i]),
            .din   (bus_wdata),
            .newest(newest[i]),
            .older (older[i])
        );
    end

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.cmd_stb = cmd_we;
        if (cmd_we)  ctl_d.cmd_code = bus_wdata;
        if (dev_we)  ctl_d.dev      = bus_wdata;
        if (dctl_we)     ctl_d.dctl = bus_wdata;
        else if (blk_we) ctl_d.dctl[TF_BYTE_W-1] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign hob      = ctl_q.dctl[TF_BYTE_W-1];
    assign cmd_stb  = ctl_q.cmd_stb;
    assign cmd_code = ctl_q.cmd_code;

    always_comb begin
        bus_rdata = '0;
        if (bus_cs && bus_rd) begin
            for (int i = 0; i < TF_N_STACK; i++) begin
                if (bus_addr == ADDR_W'(i + 1))
                    bus_rdata = hob ? older[i] : newest[i];
            end
            if (bus_addr == ADDR_W'(ADR_DEV))  bus_rdata = ctl_q.dev;
            if (bus_addr == ADDR_W'(ADR_DCTL)) bus_rdata = ctl_q.dctl;
        end
    end

    tf_param_assemble i_asm (
        .newest(newest),
        .older (older),
        .dev   (ctl_q.dev),
        .lba48 (lba48),
        .lba28 (lba28),
        .scnt28(scnt28),
        .scnt48(scnt48),
        .feat16(feat16)
    );
endmodule

// File: rtl/tf_regbank_chk.sv
module tf_regbank_chk
    import tf_regbank_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_cs,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [TF_BYTE_W-1:0]   bus_wdata,
    input logic [TF_BYTE_W-1:0]   bus_rdata,
    input logic                   hob,
    input logic                   cmd_stb,
    input logic [TF_BYTE_W-1:0]   cmd_code,
    input logic [TF_LBA48_W-1:0]  lba48,
    input logic [TF_CNT28_W-1:0]  scnt28,
    input logic [TF_CNT48_W-1:0]  scnt48,
    input logic [2*TF_BYTE_W-1:0] feat16
);
    logic wr_hit, rd_hit;
    assign wr_hit = bus_cs && bus_wr;
    assign rd_hit = bus_cs && bus_rd;

    AST_LBAL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && bus_addr == ADDR_W'(3) |=>
        lba48[7:0] == $past(bus_wdata) && lba48[31:24] == $past(lba48[7:0])); // R1
    AST_RD_FEAT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit && bus_addr == ADDR_W'(1) |->
        bus_rdata == (hob ? feat16[15:8] : feat16[7:0])); // R2
    AST_HOB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && bus_addr >= ADDR_W'(1) && bus_addr <= ADDR_W'(7) |=> !hob); // R3
    AST_HOB_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && bus_addr == ADDR_W'(8) |=> hob == $past(bus_wdata[7])); // R5
    AST_DCTL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && bus_addr == ADDR_W'(8) |=>
        $stable(lba48) && $stable(feat16) && $stable(scnt48)); // R5
    AST_CNT28_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        scnt28 != '0); // R8
    AST_CNT48_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        scnt48 != '0); // R9
    AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit && bus_addr == ADDR_W'(7) |=> cmd_stb && cmd_code == $past(bus_wdata)); // R11
    AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && bus_addr == ADDR_W'(7)) |=> !cmd_stb); // R11
    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> bus_rdata == '0); // R13
endmodule

bind tf_regbank tf_regbank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs   (bus_cs),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .hob      (hob),
    .cmd_stb  (cmd_stb),
    .cmd_code (cmd_code),
    .lba48    (lba48),
    .scnt28   (scnt28),
    .scnt48   (scnt48),
    .feat16   (feat16)
);

// File: tb/test_tf_regbank.sv
`timescale 1ns/1ps
module test_tf_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        hob, cmd_stb;
    logic [7:0]  cmd_code;
    logic [47:0] lba48;
    logic [27:0] lba28;
    logic [8:0]  scnt28;
    logic [16:0] scnt48;
    logic [15:0] feat16;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    tf_regbank i_tf_regbank (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .hob(hob), .cmd_stb(cmd_stb),
        .cmd_code(cmd_code), .lba48(lba48), .lba28(lba28),
        .scnt28(scnt28), .scnt48(scnt48), .feat16(feat16)
    );

    // entry: op[25:24] (0 write, 1 read-check, 2 write with cs low),
    // addr[23:20], data[19:12], expected[11:4], requirement number[3:0]
    localparam int NV = 30;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 4'd3, 8'h11, 8'h00, 4'd1},   // R1 LBA low push
        {2'd0, 4'd3, 8'h22, 8'h00, 4'd1},
        {2'd1, 4'd3, 8'h00, 8'h22, 4'd2},   // R2 newest with hob=0
        {2'd0, 4'd8, 8'h80, 8'h00, 4'd5},
        {2'd1, 4'd3, 8'h00, 8'h11, 4'd2},   // R2 previous with hob=1
        {2'd1, 4'd8, 8'h00, 8'h80, 4'd5},   // R5 readback
        {2'd0, 4'd4, 8'h33, 8'h00, 4'd3},
        {2'd1, 4'd8, 8'h00, 8'h00, 4'd3},   // R3 hob cleared by write
        {2'd0, 4'd8, 8'h80, 8'h00, 4'd5},
        {2'd1, 4'd4, 8'h00, 8'h00, 4'd2},
        {2'd0, 4'd4, 8'h44, 8'h00, 4'd4},   // R4 write while hob=1
        {2'd1, 4'd4, 8'h00, 8'h44, 4'd4},
        {2'd0, 4'd8, 8'h80, 8'h00, 4'd5},
        {2'd1, 4'd4, 8'h00, 8'h33, 4'd4},
        {2'd1, 4'd3, 8'h00, 8'h11, 4'd5},   // R5 no push by dctl writes
        {2'd0, 4'd0, 8'h99, 8'h00, 4'd13},  // R13 unmapped write
        {2'd1, 4'd8, 8'h00, 8'h80, 4'd13},
        {2'd1, 4'd0, 8'h00, 8'h00, 4'd13},
        {2'd0, 4'd12, 8'h5A, 8'h00, 4'd13},
        {2'd1, 4'd8, 8'h00, 8'h80, 4'd13},
        {2'd0, 4'd1, 8'hAB, 8'h00, 4'd10},
        {2'd0, 4'd1, 8'hCD, 8'h00, 4'd10},
        {2'd1, 4'd1, 8'h00, 8'hCD, 4'd2},
        {2'd0, 4'd8, 8'h80, 8'h00, 4'd5},
        {2'd1, 4'd1, 8'h00, 8'hAB, 4'd2},
        {2'd0, 4'd6, 8'hE5, 8'h00, 4'd7},   // R7 device byte
        {2'd1, 4'd6, 8'h00, 8'hE5, 4'd7},
        {2'd1, 4'd8, 8'h00, 8'h00, 4'd3},
        {2'd2, 4'd3, 8'h77, 8'h00, 4'd13},  // R13 cs low
        {2'd1, 4'd3, 8'h00, 8'h22, 4'd13}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d, input logic sel);
        @(negedge clk);
        bus_cs = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_cs = 1'b0; bus_rd = 1'b0; bus_addr = '0;
    endtask

    initial begin
        #(4 * 100000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 lba48", 64'(lba48), 64'h0);
        check("R12 hob", 64'(hob), 64'h0);
        check("R12 cmd_stb", 64'(cmd_stb), 64'h0);
        check("R12 feat16", 64'(feat16), 64'h0);
        check("R8 scnt28 zero", 64'(scnt28), 64'd256);
        check("R9 scnt48 zero", 64'(scnt48), 64'd65536);

        for (int k = 0; k < NV; k++) begin
            logic [25:0] v;
            v = VEC[k];
            if (v[25:24] == 2'd1) begin
                bus_read(v[23:20], rd);
                check($sformatf("R%0d read vec %0d", v[3:0], k), 64'(rd), 64'(v[11:4]));
            end else begin
                bus_write(v[23:20], v[19:12], v[25:24] == 2'd0);
            end
        end

        // R6 / R7 / R10 assembled values after the table
        check("R6 lba48", 64'(lba48), 64'h0033_1100_4422);
        check("R7 lba28", 64'(lba28), 64'h500_4422);
        check("R10 feat16", 64'(feat16), 64'hABCD);
        check("R13 hob after cs-low write", 64'(hob), 64'h0);

        // R8 / R9 sector count corners
        bus_write(4'd2, 8'h02, 1'b1);
        bus_write(4'd2, 8'h00, 1'b1);
        check("R8 scnt28 low zero", 64'(scnt28), 64'd256);
        check("R9 scnt48 pair", 64'(scnt48), 64'd512);
        bus_write(4'd2, 8'h00, 1'b1);
        check("R9 scnt48 all zero", 64'(scnt48), 64'd65536);
        bus_write(4'd2, 8'h01, 1'b1);
        check("R8 scnt28 one", 64'(scnt28), 64'd1);
        check("R9 scnt48 one", 64'(scnt48), 64'd1);
        bus_write(4'd2, 8'hFF, 1'b1);
        check("R9 scnt48 mixed", 64'(scnt48), 64'h01FF);

        // R11 command strobe
        bus_write(4'd7, 8'h25, 1'b1);
        check("R11 strobe high", 64'(cmd_stb), 64'h1);
        check("R11 code", 64'(cmd_code), 64'h25);
        @(negedge clk);
        check("R11 strobe drops", 64'(cmd_stb), 64'h0);
        bus_read(4'd7, rd);
        check("R13 read cmd addr", 64'(rd), 64'h0);

        // R12 reset in mid-run
        bus_write(4'd8, 8'h80, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 lba48 after reset", 64'(lba48), 64'h0);
        check("R12 hob after reset", 64'(hob), 64'h0);
        check("R12 lba28 after reset", 64'(lba28), 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule